// File: doc/BRIEF.md
# Cascadable Reloading Binary Counter

This block is a wide synchronous up-counter built from identical 8-bit slices. Each slice counts up on the rising clock edge while its active-low enable is asserted. Each slice raises an active-low flag whenever its own count is all ones. The wrapper chains the slices. A slice's enable is the OR of the chain enable and the flags of every slice below it, so a slice advances only on the cycle when all lower slices sit at all ones. The wrapper also brings out a single active-low terminal-count flag for the whole width.

A parallel-load input copies the data input into the counter on the next clock. A reload-at-top control turns the counter into a programmable divider. When the full count reaches all ones, the next enabled clock loads the data input instead of wrapping to zero. The terminal-count flag then pulses once every 2^(width) minus the loaded value clocks. For example, loading 2^32 - 113 into the default 32-bit chain gives a divide-by-113 output.

Top module: `casc_counter`

## Requirements
- R1: While `cnt_en_n` is 0 and neither load nor reload applies, the full count `q` increases by exactly one on each rising clock edge.
- R2: `tc_n` is 0 exactly when every bit of `q` is 1, and 1 otherwise.
- R3: While `cnt_en_n` is 1 and `ld_now` is 0, `q` keeps its value.
- R4: A slice advances only when every lower slice is at all ones, so carries ripple correctly across slice boundaries (for example 0x000000FF to 0x00000100, and 0x00FFFFFF to 0x01000000).
- R5: With `reload_at_top` at 0, an enabled clock at all ones wraps `q` to zero.
- R6: With `reload_at_top` at 1, an enabled clock at all ones loads `din` into `q` instead of wrapping.
- R7: In divider mode (`reload_at_top` at 1, `din` = 2^32 - 113), `tc_n` goes low once every 113 clocks.
- R8: `ld_now` at 1 loads `din` on the next clock. It takes priority over counting and acts even when `cnt_en_n` is 1.
- R9: `rst_n` at 0 clears `q` to zero on the next clock, which leaves `tc_n` at 1. Reset takes priority over load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en_n | input | 1 | Active-low count enable for the chain |
| ld_now | input | 1 | Parallel load of `din` on the next clock |
| reload_at_top | input | 1 | Reload `din` instead of wrapping at all ones |
| din | input | N_SLICES*SLICE_W | Parallel data / reload value |
| q | output | N_SLICES*SLICE_W | Current count |
| tc_n | output | 1 | Active-low terminal count, low at all ones |

## Verification
The assertions assume the control inputs and `din` hold known values from the first clock onward. They also assume every control change is sampled at a rising edge, so one edge shows the effect of the previous cycle's controls. The stimulus holds `rst_n` low from time zero and changes every input only on the falling clock edge. The assertions on increment, hold, load and reload compare each slice's count with its value one edge earlier, so they never look back past reset. The stimulus loads values just below the carry boundaries and the all-ones state. This reaches the rare ripple and reload cases in a few cycles.

// File: rtl/ctr_pkg.sv
// Package: shared sizing defaults for the cascadable counter.
// Assumes: slices are of equal width; the chain width is their product.
package ctr_pkg;
    localparam int unsigned SLICE_BITS  = 8;
    localparam int unsigned SLICE_COUNT = 4;
endpackage

// File: rtl/ctr_slice.sv
// Module: one W-bit up-counter slice with parallel load, reload at all
// ones and an active-low all-ones flag.
// Assumes: synchronous active-low reset; enable is active low; load wins
// over counting; the reload input is only honoured at all ones.
module ctr_slice #(
    parameter int unsigned W = ctr_pkg::SLICE_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_n,
    input  logic         ld_now,
    input  logic         reload,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         top_n
);
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] q_r;
    logic         at_top;

    // Purpose: detect the all-ones state of this slice.
    always_comb at_top = (q_r == ALL1);

    // Purpose: reset, load, reload-at-top or increment the slice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_r <= '0;
        else if (ld_now)
            q_r <= din;
        else if (!cnt_en_n) begin
            if (at_top && reload)
                q_r <= din;
            else
                q_r <= q_r + ONE;
        end
    end

    assign q     = q_r;
    assign top_n = ~at_top;

    AST_SLICE_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_now && !cnt_en_n && !(q == ALL1 && reload)) |=> (q == $past(q) + ONE)); // R1
    AST_SLICE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_now && !cnt_en_n && q == (ALL1 - ONE)) |=> !top_n); // R2
    AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_now && cnt_en_n) |=> $stable(q)); // R3
    AST_SLICE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_now && !cnt_en_n && reload && !top_n) |=> (q == $past(din))); // R6
    AST_SLICE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_now |=> (q == $past(din))); // R8
    AST_SLICE_RESET: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (q == '0 && top_n)); // R9
endmodule

// File: rtl/ctr_enable_chain.sv
// Module: builds each slice's active-low enable as the OR of the chain
// enable and the all-ones flags of every lower slice, plus the chain flag.
// Assumes: flags are active low; slice 0 is least significant.
module ctr_enable_chain #(
    parameter int unsigned N = ctr_pkg::SLICE_COUNT
) (
    input  logic         chain_en_n,
    input  logic [N-1:0] slice_top_n,
    output logic [N-1:0] slice_en_n,
    output logic         chain_top_n
);
    logic [N:0] pre;

    assign pre[0] = chain_en_n;

    // Purpose: running OR of lower flags, one stage per slice.
    for (genvar k = 0; k < N; k++) begin : g_or
        assign slice_en_n[k] = pre[k];
        assign pre[k+1]      = pre[k] | slice_top_n[k];
    end

    assign chain_top_n = |slice_top_n;
endmodule

// File: rtl/casc_counter.sv
// Module: wide counter made of N_SLICES chained slices with shared load,
// reload-at-top divider mode and a chain-wide active-low terminal count.
// Assumes: synchronous active-low reset; reload is gated so that only the
// full-width all-ones state triggers it.
module casc_counter #(
    parameter int unsigned N_SLICES = ctr_pkg::SLICE_COUNT,
    parameter int unsigned SLICE_W  = ctr_pkg::SLICE_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cnt_en_n,
    input  logic                          ld_now,
    input  logic                          reload_at_top,
    input  logic [N_SLICES*SLICE_W-1:0]   din,
    output logic [N_SLICES*SLICE_W-1:0]   q,
    output logic                          tc_n
);
    localparam int unsigned TOT_W = N_SLICES * SLICE_W;
    localparam logic [TOT_W-1:0] FULL = '1;

    logic [N_SLICES-1:0] top_n_v;
    logic [N_SLICES-1:0] en_n_v;
    logic                chain_top_n;
    logic                reload_g;

    // Purpose: only reload when the whole chain is at all ones.
    always_comb reload_g = reload_at_top & ~chain_top_n;

    ctr_enable_chain #(.N(N_SLICES)) u_chain (
        .chain_en_n  (cnt_en_n),
        .slice_top_n (top_n_v),
        .slice_en_n  (en_n_v),
        .chain_top_n (chain_top_n)
    );

    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        ctr_slice #(.W(SLICE_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_en_n (en_n_v[k]),
            .ld_now   (ld_now),
            .reload   (reload_g),
            .din      (din[k*SLICE_W +: SLICE_W]),
            .q        (q[k*SLICE_W +: SLICE_W]),
            .top_n    (top_n_v[k])
        );
    end

    assign tc_n = chain_top_n;

    AST_WIDE_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_now && !cnt_en_n && !reload_at_top && q == FULL) |=> (q == '0)); // R5
    AST_WIDE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_now && !cnt_en_n && !(q == FULL && reload_at_top)) |=> (q == $past(q) + 1'b1)); // R4
    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_now && cnt_en_n) |=> $stable(q)); // R3
endmodule

// File: tb/casc_counter_tb.sv
`timescale 1ns/1ps
module casc_counter_tb_top;
    localparam int unsigned NS = 4;
    localparam int unsigned SW = 8;
    localparam int unsigned TW = NS * SW;
    localparam logic [TW-1:0] FULL = '1;

    typedef struct {
        logic [TW-1:0] q;
        logic          tc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en_n = 1'b1;
    logic          ld_now = 1'b0;
    logic          reload_at_top = 1'b0;
    logic [TW-1:0] din = '0;
    logic [TW-1:0] q;
    logic          tc_n;

    int            errors = 0;
    int            checks = 0;
    exp_t          sbq[$];
    logic [TW-1:0] ref_q = '0;
    logic          div_watch = 1'b0;
    int            cyc = 0;
    int            div_last = -1;
    logic          done = 1'b0;

    always #2.5 clk = ~clk;

    casc_counter #(.N_SLICES(NS), .SLICE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .ld_now(ld_now),
        .reload_at_top(reload_at_top), .din(din), .q(q), .tc_n(tc_n)
    );

    // Driver: apply one cycle of inputs and push the expected result.
    task automatic step(input logic r, input logic ld, input logic en_n,
                        input logic rl, input logic [TW-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r; ld_now = ld; cnt_en_n = en_n; reload_at_top = rl; din = d;
        if (!r)                          ref_q = '0;
        else if (ld)                     ref_q = d;
        else if (!en_n) begin
            if (ref_q == FULL && rl)     ref_q = d;
            else                         ref_q = ref_q + 1'b1;
        end
        e.q = ref_q; e.tc = ~(ref_q == FULL); e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: pop and compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (q !== e.q || tc_n !== e.tc) begin
                    errors++;
                    $display("FAIL %s: actual q=%h tc_n=%b expected q=%h tc_n=%b",
                             e.tag, q, tc_n, e.q, e.tc);
                end
            end
            if (div_watch && tc_n === 1'b0) begin
                if (div_last >= 0) begin
                    checks++;
                    if (cyc - div_last != 113) begin
                        errors++;
                        $display("FAIL R7: actual period=%0d expected=113", cyc - div_last);
                    end
                end
                div_last = cyc;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        step(1'b0, 1'b0, 1'b1, 1'b0, '0, "R9 reset");
        step(1'b0, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, "R9 reset over load");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R1 count");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, '0, "R3 hold");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_00FD, "R8 load while disabled");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R4 carry byte0");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'h00FF_FFFE, "R8 load");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R4 carry three slices");
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'h1234_5678, "R8 load over count");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFC, "R8 load near top");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R2 approach top");
        step(1'b1, 1'b0, 1'b1, 1'b0, '0, "R2 hold at top");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R5 rollover");
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFE, "R8 load");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_A5A5, "R6 reload");
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_1000, "R6 reload ignored below top");
        step(1'b1, 1'b1, 1'b0, 1'b1, FULL - 32'd112, "R7 divider load");
        div_watch = 1'b1;
        for (int i = 0; i < 350; i++) step(1'b1, 1'b0, 1'b0, 1'b1, FULL - 32'd112, "R7 divide");
        step(1'b1, 1'b0, 1'b1, 1'b1, FULL - 32'd112, "R3 hold");
        div_watch = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0, '0, "R9 final reset");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule